// File: doc/BRIEF.md
# Effective Address Generation Unit

This unit sits in the address stage of a load/store pipeline. For each operation it forms the memory effective address. Its inputs are an addressing-mode code, a base register value, an index register value, a signed displacement, a second (outer) signed displacement and the program counter. For the four auto-modify modes it also returns the updated base register value, together with a write-enable for that value.

Most modes finish in one cycle. The two memory-indirect modes first read a pointer word from memory. They do this over a request channel with valid/ready handshaking and a response channel with valid/ready handshaking, and `busy` stays high until the final address is ready. Each completed operation produces a one-cycle `done` pulse. The `ea`, `wb_data` and `wb_en` outputs are valid while `done` is high.

Top module: `ea_gen`

## Requirements
- R1: During and after reset, `busy`, `done`, `wb_en`, `req_valid` and `rsp_ready` are 0, and `ea` is 0.
- R2: Operation codes 0 to 9 and 12 to 15 are non-indirect. When `start` is high and `busy` is low, such an operation pulses `done` on the next clock edge, and `busy` never rises.
- R3: Code 1 (post-increment) gives `ea` = base and writeback = base + 2^`opsize`. Code 4 (post-decrement) gives `ea` = base and writeback = base − 2^`opsize`. `opsize` values 0..3 mean 1, 2, 4 or 8 bytes.
- R4: Code 3 (pre-increment) sets both `ea` and the writeback value to base + 2^`opsize`. Code 2 (pre-decrement) sets both to base − 2^`opsize`.
- R5: Displacements are sign-extended from 16 bits. Code 0 gives `ea` = base. Code 5 gives base + displacement. Code 7 (absolute short) gives the displacement alone.
- R6: The scaled index is the index value shifted left by `scale` (×1, ×2, ×4, ×8). The index value is the full index register when `idx_short` is 0. When `idx_short` is 1, it is bits 15:0 of the index register, sign-extended. Code 6 gives base + scaled index + displacement.
- R7: Code 8 gives pc + displacement. Code 9 gives pc + scaled index + displacement.
- R8: Code 10 (pre-indexed indirect) requests the pointer at base + displacement + scaled index. The final `ea` is the returned word + outer displacement.
- R9: Code 11 (post-indexed indirect) requests the pointer at base + displacement. The final `ea` is the returned word + scaled index + outer displacement.
- R10: The pointer fetch has two phases. First `req_valid` stays high, with `req_addr` stable, until `req_ready` is seen. Then `rsp_ready` stays high until `rsp_valid` is seen. `done` pulses on the clock edge after the response is accepted, and `busy` is high from the edge after `start` until that edge.
- R11: `wb_en` is high only together with `done`, and only for codes 1 to 4.
- R12: A `start` while `busy` is high is ignored. It does not change the request address, the result or the timing of the operation in progress.
- R13: All address sums are unsigned and wrap modulo 2^32.
- R14: Codes 12 to 15 behave exactly like code 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin an operation (accepted when not busy) |
| mode | input | 4 | Addressing-mode code |
| opsize | input | 2 | Operand size, log2 bytes |
| scale | input | 2 | Index scale, log2 factor |
| idx_short | input | 1 | Use sign-extended low 16 bits of the index |
| base_reg | input | 32 | Base register value |
| index_reg | input | 32 | Index register value |
| pc | input | 32 | Current program counter |
| disp | input | 16 | Base displacement |
| outer_disp | input | 16 | Outer displacement for indirect modes |
| req_valid | output | 1 | Pointer fetch request valid |
| req_addr | output | 32 | Pointer fetch address |
| req_ready | input | 1 | Memory accepts the request |
| rsp_valid | input | 1 | Pointer word returned |
| rsp_data | input | 32 | Pointer word |
| rsp_ready | output | 1 | Unit is waiting for the pointer word |
| busy | output | 1 | Indirect operation in progress |
| done | output | 1 | One-cycle completion pulse |
| ea | output | 32 | Effective address |
| wb_en | output | 1 | Base writeback enable |
| wb_data | output | 32 | Updated base register value |

## Verification
The hardest case to reach is a new `start` that arrives while a pointer fetch is stalled mid-handshake, with the base, index and mode inputs also changing at that moment. A correct unit must ignore both the new `start` and the new operand values. The bench drives an indirect operation and holds `req_ready` low, then `rsp_valid` low, for a chosen number of cycles. During those cycles it pulses `start` with a different mode and different operands. It then checks that the request address stayed put, that `done` appeared only at the predicted edge, and that the final address uses the operands captured at the start. Wrap-around is covered by base values next to zero and to the top of the address space.

// File: rtl/ea_gen.sv
module ea_gen #(
  parameter int AW = 32,
  parameter int DW = 16,
  parameter int IW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [3:0]    mode,
  input  logic [1:0]    opsize,
  input  logic [1:0]    scale,
  input  logic          idx_short,
  input  logic [AW-1:0] base_reg,
  input  logic [AW-1:0] index_reg,
  input  logic [AW-1:0] pc,
  input  logic [DW-1:0] disp,
  input  logic [DW-1:0] outer_disp,
  output logic          req_valid,
  output logic [AW-1:0] req_addr,
  input  logic          req_ready,
  input  logic          rsp_valid,
  input  logic [AW-1:0] rsp_data,
  output logic          rsp_ready,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] ea,
  output logic          wb_en,
  output logic [AW-1:0] wb_data
);

  typedef enum logic [1:0] {S_IDLE, S_REQ, S_RSP} state_t;
  state_t state;

  logic [AW-1:0] disp_x, odisp_x, idx_raw, idx_x, step, addend;
  logic [AW-1:0] ea_n, wb_n, ptr_n, add_n;
  logic          wbe_n, ind_n, accept;

  assign disp_x  = {{(AW-DW){disp[DW-1]}}, disp};
  assign odisp_x = {{(AW-DW){outer_disp[DW-1]}}, outer_disp};
  assign idx_raw = idx_short ? {{(AW-IW){index_reg[IW-1]}}, index_reg[IW-1:0]} : index_reg;
  assign idx_x   = idx_raw << scale;
  assign step    = {{(AW-1){1'b0}}, 1'b1} << opsize;
  assign accept  = start && (state == S_IDLE);

  always_comb begin
    ea_n  = base_reg;
    wb_n  = base_reg;
    wbe_n = 1'b0;
    ind_n = 1'b0;
    ptr_n = base_reg + disp_x;
    add_n = odisp_x;
    case (mode)
      4'd1: begin wb_n = base_reg + step; wbe_n = 1'b1; end
      4'd2: begin ea_n = base_reg - step; wb_n = ea_n; wbe_n = 1'b1; end
      4'd3: begin ea_n = base_reg + step; wb_n = ea_n; wbe_n = 1'b1; end
      4'd4: begin wb_n = base_reg - step; wbe_n = 1'b1; end
      4'd5: ea_n = base_reg + disp_x;
      4'd6: ea_n = base_reg + idx_x + disp_x;
      4'd7: ea_n = disp_x;
      4'd8: ea_n = pc + disp_x;
      4'd9: ea_n = pc + idx_x + disp_x;
      4'd10: begin ind_n = 1'b1; ptr_n = base_reg + disp_x + idx_x; end
      4'd11: begin ind_n = 1'b1; add_n = idx_x + odisp_x; end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      done     <= 1'b0;
      wb_en    <= 1'b0;
      ea       <= '0;
      wb_data  <= '0;
      req_addr <= '0;
      addend   <= '0;
    end else begin
      done  <= 1'b0;
      wb_en <= 1'b0;
      case (state)
        S_IDLE: if (accept) begin
          if (ind_n) begin
            req_addr <= ptr_n;
            addend   <= add_n;
            state    <= S_REQ;
          end else begin
            ea      <= ea_n;
            wb_data <= wb_n;
            wb_en   <= wbe_n;
            done    <= 1'b1;
          end
        end
        S_REQ: if (req_ready) state <= S_RSP;
        S_RSP: if (rsp_valid) begin
          ea    <= rsp_data + addend;
          done  <= 1'b1;
          state <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign req_valid = (state == S_REQ);
  assign rsp_ready = (state == S_RSP);
  assign busy      = (state != S_IDLE);

  // R2
  simple_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && mode != 4'd10 && mode != 4'd11 |=> done && !busy);

  // R10
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_addr));

  // R10
  rsp_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_ready |-> busy && !req_valid);

  // R11
  wb_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done);

  // R3
  post_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start && !busy && mode == 4'd1 |=> wb_en && ea == $past(base_reg)
      && wb_data == $past(base_reg) + ({{(AW-1){1'b0}}, 1'b1} << $past(opsize)));

  // R12
  busy_ignore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> !done);

endmodule

// File: tb/ea_gen_test.sv
`timescale 1ns/1ps
module ea_gen_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [3:0]  mode = '0;
  logic [1:0]  opsize = '0, scale = '0;
  logic        idx_short = 1'b0;
  logic [31:0] base_reg = '0, index_reg = '0, pc = '0;
  logic [15:0] disp = '0, outer_disp = '0;
  logic        req_ready = 1'b0, rsp_valid = 1'b0;
  logic [31:0] rsp_data = '0;
  logic        req_valid, rsp_ready, busy, done, wb_en;
  logic [31:0] req_addr, ea, wb_data;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  ea_gen uut (
    .clk(clk), .rst_n(rst_n), .start(start), .mode(mode), .opsize(opsize),
    .scale(scale), .idx_short(idx_short), .base_reg(base_reg),
    .index_reg(index_reg), .pc(pc), .disp(disp), .outer_disp(outer_disp),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ready(rsp_ready),
    .busy(busy), .done(done), .ea(ea), .wb_en(wb_en), .wb_data(wb_data)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0], a[31:16]} ^ 32'h5A3C_0F11;
  endfunction

  function automatic longint sidx(input bit sh, input logic [31:0] ix, input logic [1:0] sc);
    longint v;
    v = sh ? longint'($signed(ix[15:0])) : longint'(ix);
    return v * (longint'(1) << sc);
  endfunction

  function automatic logic [31:0] wrap(input longint v);
    return v[31:0];
  endfunction

  task automatic drive(input logic [3:0] m, input logic [1:0] sz, input logic [1:0] sc,
                       input bit sh, input logic [31:0] b, input logic [31:0] ix,
                       input logic [31:0] p, input logic [15:0] d, input logic [15:0] od);
    mode = m; opsize = sz; scale = sc; idx_short = sh; base_reg = b;
    index_reg = ix; pc = p; disp = d; outer_disp = od;
  endtask

  task automatic run_simple(input string tag, input logic [3:0] m, input logic [1:0] sz,
                            input logic [1:0] sc, input bit sh, input logic [31:0] b,
                            input logic [31:0] ix, input logic [31:0] p,
                            input logic [15:0] d);
    longint dv, bv, step, e, w;
    bit we;
    dv = longint'($signed(d));
    bv = longint'(b);
    step = longint'(1) << sz;
    e = bv; w = bv; we = 0;
    if (m == 1) begin w = bv + step; we = 1; end
    else if (m == 2) begin e = bv - step; w = e; we = 1; end
    else if (m == 3) begin e = bv + step; w = e; we = 1; end
    else if (m == 4) begin w = bv - step; we = 1; end
    else if (m == 5) e = bv + dv;
    else if (m == 6) e = bv + sidx(sh, ix, sc) + dv;
    else if (m == 7) e = dv;
    else if (m == 8) e = longint'(p) + dv;
    else if (m == 9) e = longint'(p) + sidx(sh, ix, sc) + dv;
    @(negedge clk);
    drive(m, sz, sc, sh, b, ix, p, d, 16'h0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " done"}, {31'b0, done}, 32'd1);
    check({tag, " busy"}, {31'b0, busy}, 32'd0);
    check({tag, " ea"}, ea, wrap(e));
    check({tag, " wb_en R11"}, {31'b0, wb_en}, {31'b0, we});
    if (we) check({tag, " wb_data"}, wb_data, wrap(w));
    @(negedge clk);
    check({tag, " done pulse R2"}, {31'b0, done}, 32'd0);
  endtask

  task automatic run_ind(input string tag, input logic [3:0] m, input logic [1:0] sc,
                         input bit sh, input logic [31:0] b, input logic [31:0] ix,
                         input logic [15:0] d, input logic [15:0] od,
                         input int req_wait, input int rsp_wait, input bit poke);
    longint ptr, e;
    logic [31:0] w;
    ptr = longint'(b) + longint'($signed(d));
    if (m == 10) ptr += sidx(sh, ix, sc);
    w = mem_word(wrap(ptr));
    e = longint'(w) + longint'($signed(od));
    if (m == 11) e += sidx(sh, ix, sc);
    @(negedge clk);
    drive(m, 2'd0, sc, sh, b, ix, 32'h0, d, od);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    check({tag, " busy R10"}, {31'b0, busy}, 32'd1);
    check({tag, " req_valid R10"}, {31'b0, req_valid}, 32'd1);
    check({tag, " req_addr"}, req_addr, wrap(ptr));
    for (int i = 0; i < req_wait; i++) begin
      if (poke) begin
        drive(4'd0, 2'd1, 2'd0, 1'b0, ~b, ~ix, 32'h0, ~d, ~od);
        start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      check({tag, " hold req R10"}, {31'b0, req_valid}, 32'd1);
      check({tag, " stable addr R12"}, req_addr, wrap(ptr));
      check({tag, " no early done R12"}, {31'b0, done}, 32'd0);
    end
    req_ready = 1'b1;
    @(negedge clk);
    req_ready = 1'b0;
    check({tag, " rsp_ready R10"}, {31'b0, rsp_ready}, 32'd1);
    check({tag, " req dropped R10"}, {31'b0, req_valid}, 32'd0);
    for (int i = 0; i < rsp_wait; i++) begin
      if (poke) begin
        drive(4'd5, 2'd2, 2'd3, 1'b1, b ^ 32'h0F0F_0000, ix + 32'd9, 32'h0, d + 16'd3, od - 16'd5);
        start = 1'b1;
      end
      @(negedge clk);
      start = 1'b0;
      check({tag, " wait rsp R10"}, {31'b0, rsp_ready}, 32'd1);
      check({tag, " no done R12"}, {31'b0, done}, 32'd0);
    end
    rsp_valid = 1'b1;
    rsp_data = w;
    @(negedge clk);
    rsp_valid = 1'b0;
    rsp_data = 32'h0;
    check({tag, " done R10"}, {31'b0, done}, 32'd1);
    check({tag, " busy clear R10"}, {31'b0, busy}, 32'd0);
    check({tag, " ea"}, ea, wrap(e));
    check({tag, " wb_en R11"}, {31'b0, wb_en}, 32'd0);
    @(negedge clk);
    check({tag, " done pulse"}, {31'b0, done}, 32'd0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 busy", {31'b0, busy}, 32'd0);
    check("R1 done", {31'b0, done}, 32'd0);
    check("R1 req_valid", {31'b0, req_valid}, 32'd0);
    check("R1 rsp_ready", {31'b0, rsp_ready}, 32'd0);
    check("R1 wb_en", {31'b0, wb_en}, 32'd0);
    check("R1 ea", ea, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {31'b0, busy | done}, 32'd0);

    run_simple("R5 reg indirect", 4'd0, 2'd2, 2'd0, 0, 32'h1000_2000, 32'h0, 32'h0, 16'h0);
    run_simple("R3 post-inc", 4'd1, 2'd2, 2'd0, 0, 32'h0000_4000, 32'h0, 32'h0, 16'h0);
    run_simple("R3 post-dec", 4'd4, 2'd0, 2'd0, 0, 32'h0000_4000, 32'h0, 32'h0, 16'h0);
    run_simple("R4 pre-dec", 4'd2, 2'd3, 2'd0, 0, 32'h0000_4000, 32'h0, 32'h0, 16'h0);
    run_simple("R4 pre-inc", 4'd3, 2'd1, 2'd0, 0, 32'h0000_4000, 32'h0, 32'h0, 16'h0);
    run_simple("R5 base+neg disp", 4'd5, 2'd0, 2'd0, 0, 32'h0000_1000, 32'h0, 32'h0, 16'hFFF0);
    run_simple("R6 full index x4", 4'd6, 2'd0, 2'd2, 0, 32'h0001_0000, 32'h0000_0100, 32'h0, 16'h0010);
    run_simple("R6 short index neg x8", 4'd6, 2'd0, 2'd3, 1, 32'h0001_0000, 32'h7777_FFFE, 32'h0, 16'h0004);
    run_simple("R5 absolute short", 4'd7, 2'd0, 2'd0, 0, 32'hDEAD_BEEF, 32'h0, 32'h0, 16'h8000);
    run_simple("R7 pc+disp", 4'd8, 2'd0, 2'd0, 0, 32'hDEAD_BEEF, 32'h0, 32'h0040_0000, 16'hFFFC);
    run_simple("R7 pc+index", 4'd9, 2'd0, 2'd1, 0, 32'h0, 32'h0000_0030, 32'h0040_0000, 16'h0008);
    run_simple("R14 reserved code", 4'd13, 2'd1, 2'd1, 1, 32'h0ABC_0000, 32'h1234, 32'h99, 16'h77);
    run_simple("R14 reserved code 15", 4'd15, 2'd3, 2'd2, 0, 32'h0000_0F00, 32'h4, 32'h8, 16'h1);
    run_simple("R13 wrap post-inc", 4'd1, 2'd2, 2'd0, 0, 32'hFFFF_FFFE, 32'h0, 32'h0, 16'h0);
    run_simple("R13 wrap pre-dec", 4'd2, 2'd0, 2'd0, 0, 32'h0000_0000, 32'h0, 32'h0, 16'h0);
    run_simple("R13 wrap pc", 4'd8, 2'd0, 2'd0, 0, 32'h0, 32'h0, 32'hFFFF_FFF0, 16'h0020);

    run_ind("R8 pre-indexed", 4'd10, 2'd2, 0, 32'h0002_0000, 32'h0000_0010, 16'h0100, 16'hFFF8, 2, 3, 1);
    run_ind("R9 post-indexed", 4'd11, 2'd1, 0, 32'h0003_0000, 32'h0000_0008, 16'hFF00, 16'h0020, 0, 0, 0);
    run_ind("R9 post-indexed short idx", 4'd11, 2'd3, 1, 32'h0004_0000, 32'hABCD_FFF0, 16'h0004, 16'h0002, 1, 1, 1);
    run_ind("R8 pre-indexed short idx", 4'd10, 2'd0, 1, 32'h0005_0000, 32'h1111_8000, 16'h0, 16'h7FFF, 3, 0, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule